// File: doc/BRIEF.md
# Timing Event Generator with Playback Sequencer

This block is the sending end of a one-way timing link. On every clock it builds a 16-bit frame. The lower byte holds an 8-bit event code. The upper byte carries eight discrete clock lines that are passed straight through. When nothing is to be sent, the code byte is zero (the null event). Receivers give no acknowledgement.

Events come from three kinds of source:
- eight asynchronous hardware trigger lines, each with its own programmable code;
- a software strobe that carries a code;
- a playback sequencer.

The sequencer owns two banks of stored entries. Each entry is an event code plus the step number at which it is due. A single reference pulse starts playback of the active bank. Steps advance on a step clock that is derived from a revolution-rate tick and divided by a programmable factor.

The two banks work as a ping-pong pair. The host can fill one bank while the other plays. The host requests which bank is active, and a switch requested during playback waits until the current sequence has finished. When two sources fire in the same cycle, a fixed priority picks the winner. The losing event is kept for exactly one extra cycle.

Top module: `timing_event_gen`

## Requirements
- R1: After reset, `frame_out` is 0, `seq_busy` is 0 and `active_bank` is 0.
- R2: In a cycle with no pending or new event, the next frame's bits [7:0] are 0x00. Bits [15:8] of every frame equal `dclk_bits` as sampled at the edge that produced the frame.
- R3: A `sw_we` strobe with a nonzero `sw_code` puts that code in bits [7:0] of the frame registered at the same clock edge. A strobe with code 0x00 sends nothing.
- R4: A rising edge on `trig_in[i]` sends the code programmed for line i (written through `trig_cfg_*`) in the frame registered on the third edge after the input rises. A line whose code is 0x00 (the reset value) sends nothing. If several lines rise together, only the lowest-numbered line that has a nonzero code is sent.
- R5: The fixed priority is hardware, then sequencer, then software. A source that loses holds its event for exactly one more cycle, and that event is sent if the source wins in that cycle.
- R6: A `ref_trig` pulse while idle starts playback at entry 0 with the step count at 0, and sets `seq_busy`. An entry due at step 0 appears in the frame registered on the third edge after the pulse. A `ref_trig` pulse during playback has no effect.
- R7: The step count advances once for every `step_div` pulses of `rev_tick` (a value of 0 acts as 1). An entry is sent once the step count has reached its step field. Entries are sent in address order, at most one per cycle.
- R8: An entry whose code is 0xFF ends playback and clears `seq_busy`, without sending an event. Playback also ends after the last address is sent.
- R9: While idle, `active_bank` follows `bank_req` with one cycle of delay. During playback, `active_bank` stays fixed, and a pending change is applied at the edge where playback ends.
- R10: A RAM write to the active bank during playback is ignored. A write to the other bank, or to any bank while idle, is stored.
- R11: A trigger line held high sends its event only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | NUM_TRIG | Asynchronous hardware trigger lines |
| trig_cfg_we | input | 1 | Write strobe for a trigger code register |
| trig_cfg_idx | input | clog2(NUM_TRIG) | Trigger line selected for the write |
| trig_cfg_code | input | 8 | Code value to store for that line |
| sw_we | input | 1 | Software event strobe |
| sw_code | input | 8 | Software event code |
| ram_we | input | 1 | Sequence entry write strobe |
| ram_bank | input | 1 | Bank to write |
| ram_addr | input | clog2(DEPTH) | Entry address |
| ram_code | input | 8 | Entry event code (0xFF ends playback) |
| ram_step | input | STEP_W | Step at which the entry is due |
| bank_req | input | 1 | Requested active bank |
| step_div | input | DIV_W | Revolution ticks per step |
| rev_tick | input | 1 | Revolution-rate tick, one cycle wide |
| ref_trig | input | 1 | Reference pulse that starts playback |
| dclk_bits | input | 8 | Discrete clock lines for the upper byte |
| frame_out | output | 16 | Transmitted frame |
| seq_busy | output | 1 | Playback in progress |
| active_bank | output | 1 | Bank used for playback |

## Verification
Each source has its own fixed latency:
- a software strobe shows up in `frame_out` one edge after it is applied;
- a trigger line takes three edges: two synchronizer stages, then the frame register;
- a reference pulse, or the revolution tick that completes a step, takes three edges: the control update, the sequencer output register, then the frame register.

The bench drives inputs on the falling edge and reads outputs on the falling edge exactly that many edges later. It also reads one cycle after that, to confirm that an event appears once and that a losing event shows up in the next frame. Status outputs (`seq_busy`, `active_bank`) are read at the same falling edge as the last frame of a sequence, because playback ends on that edge.

// File: rtl/evg_pkg.sv
package evg_pkg;

    localparam int CODE_W   = 8;
    localparam int NUM_SRC  = 3;
    localparam logic [CODE_W-1:0] NULL_CODE = '0;
    localparam logic [CODE_W-1:0] STOP_CODE = '1;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic  vld;
        code_t code;
    } evt_t;

    // source slots in priority order, lowest index wins
    typedef enum logic [1:0] {
        SRC_HW  = 2'd0,
        SRC_SEQ = 2'd1,
        SRC_SW  = 2'd2
    } src_e;

    function automatic evt_t make_evt(code_t c, logic v);
        evt_t e;
        e.vld  = v && (c != NULL_CODE);
        e.code = c;
        return e;
    endfunction

endpackage

// File: rtl/evg_trig_in.sv
module evg_trig_in
    import evg_pkg::*;
#(
    parameter int NUM_TRIG = 8,
    localparam int TIDX_W  = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic              cfg_we,
    input  logic [TIDX_W-1:0] cfg_idx,
    input  code_t             cfg_code,
    output evt_t              hw_evt
);

    logic [NUM_TRIG-1:0] sync1_q, sync2_q, prev_q;
    logic [NUM_TRIG-1:0] rise;
    code_t               lane_code [NUM_TRIG];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            sync1_q <= trig_in;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_TRIG; i++) begin
            if (rst)
                lane_code[i] <= NULL_CODE;
            else if (cfg_we && cfg_idx == TIDX_W'(i))
                lane_code[i] <= cfg_code;
        end
    end

    assign rise = sync2_q & ~prev_q;

    // lowest-numbered enabled lane wins
    always_comb begin
        hw_evt = '0;
        for (int i = NUM_TRIG - 1; i >= 0; i--) begin
            if (rise[i] && lane_code[i] != NULL_CODE)
                hw_evt = make_evt(lane_code[i], 1'b1);
        end
    end

    // R4
    hw_from_input_chk: assert property (@(posedge clk) disable iff (rst)
        hw_evt.vld |-> $past(|trig_in, 2));

endmodule

// File: rtl/evg_seq.sv
module evg_seq
    import evg_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int STEP_W  = 12,
    parameter int DIV_W   = 8,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  code_t             wr_code,
    input  logic [STEP_W-1:0] wr_step,
    input  logic              bank_req,
    input  logic [DIV_W-1:0]  step_div,
    input  logic              rev_tick,
    input  logic              ref_trig,
    output evt_t              seq_evt,
    output logic              busy,
    output logic              active
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        code_t             code;
        logic [STEP_W-1:0] step;
    } entry_t;

    entry_t            mem [2][DEPTH];
    entry_t            cur;
    logic [ADDR_W-1:0] addr_q;
    logic [STEP_W-1:0] step_cnt;
    logic [DIV_W-1:0]  pre_cnt;
    logic [DIV_W-1:0]  last_pre;
    logic              wr_ok;

    assign last_pre = (step_div == '0) ? '0 : step_div - DIV_W'(1);
    assign cur      = mem[active][addr_q];
    assign wr_ok    = wr_en && !(busy && wr_bank == active);

    // storage: empty banks hold the stop code
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++)
                for (int a = 0; a < DEPTH; a++)
                    mem[b][a] <= '{code: STOP_CODE, step: '0};
        end else if (wr_ok) begin
            mem[wr_bank][wr_addr] <= '{code: wr_code, step: wr_step};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            active   <= 1'b0;
            addr_q   <= '0;
            step_cnt <= '0;
            pre_cnt  <= '0;
            seq_evt  <= '0;
        end else begin
            seq_evt <= '0;
            if (!busy) begin
                active <= bank_req;
                if (ref_trig) begin
                    busy     <= 1'b1;
                    addr_q   <= '0;
                    step_cnt <= '0;
                    pre_cnt  <= '0;
                end
            end else begin
                if (rev_tick) begin
                    if (pre_cnt >= last_pre) begin
                        pre_cnt  <= '0;
                        step_cnt <= step_cnt + STEP_W'(1);
                    end else begin
                        pre_cnt <= pre_cnt + DIV_W'(1);
                    end
                end
                if (cur.code == STOP_CODE) begin
                    busy   <= 1'b0;
                    active <= bank_req;
                end else if (step_cnt >= cur.step) begin
                    seq_evt <= make_evt(cur.code, 1'b1);
                    if (addr_q == LAST_ADDR) begin
                        busy   <= 1'b0;
                        active <= bank_req;
                    end else begin
                        addr_q <= addr_q + ADDR_W'(1);
                    end
                end
            end
        end
    end

    // R6
    start_by_ref_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ref_trig));

    // R7
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(rev_tick)) |-> $stable(step_cnt));

    // R9
    bank_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(active));

endmodule

// File: rtl/evg_arb.sv
module evg_arb
    import evg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  evt_t  hw_evt,
    input  evt_t  seq_evt,
    input  evt_t  sw_evt,
    input  code_t dclk_bits,
    output logic [2*CODE_W-1:0] frame_out
);

    evt_t [NUM_SRC-1:0] src_in;
    evt_t [NUM_SRC-1:0] pend_q;
    evt_t [NUM_SRC-1:0] cand;
    logic               any_win;
    logic [1:0]         win_idx;

    assign src_in[SRC_HW]  = hw_evt;
    assign src_in[SRC_SEQ] = seq_evt;
    assign src_in[SRC_SW]  = sw_evt;

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_cand
            assign cand[s] = pend_q[s].vld ? pend_q[s] : src_in[s];
        end
    endgenerate

    always_comb begin
        any_win = 1'b0;
        win_idx = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (cand[s].vld) begin
                any_win = 1'b1;
                win_idx = 2'(s);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_out <= '0;
            pend_q    <= '0;
        end else begin
            frame_out <= {dclk_bits, any_win ? cand[win_idx].code : NULL_CODE};
            for (int s = 0; s < NUM_SRC; s++) begin
                if (src_in[s].vld && !pend_q[s].vld && win_idx != 2'(s))
                    pend_q[s] <= src_in[s];
                else
                    pend_q[s] <= '0;
            end
        end
    end

    // R2
    null_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !(cand[0].vld || cand[1].vld || cand[2].vld) |=> frame_out[CODE_W-1:0] == NULL_CODE);

    // R5
    hw_first_chk: assert property (@(posedge clk) disable iff (rst)
        hw_evt.vld |=> frame_out[CODE_W-1:0] == $past(hw_evt.code));

endmodule

// File: rtl/timing_event_gen.sv
module timing_event_gen
    import evg_pkg::*;
#(
    parameter int NUM_TRIG = 8,
    parameter int DEPTH    = 16,
    parameter int STEP_W   = 12,
    parameter int DIV_W    = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_TRIG-1:0]          trig_in,
    input  logic                         trig_cfg_we,
    input  logic [$clog2(NUM_TRIG)-1:0]  trig_cfg_idx,
    input  logic [7:0]                   trig_cfg_code,
    input  logic                         sw_we,
    input  logic [7:0]                   sw_code,
    input  logic                         ram_we,
    input  logic                         ram_bank,
    input  logic [$clog2(DEPTH)-1:0]     ram_addr,
    input  logic [7:0]                   ram_code,
    input  logic [STEP_W-1:0]            ram_step,
    input  logic                         bank_req,
    input  logic [DIV_W-1:0]             step_div,
    input  logic                         rev_tick,
    input  logic                         ref_trig,
    input  logic [7:0]                   dclk_bits,
    output logic [15:0]                  frame_out,
    output logic                         seq_busy,
    output logic                         active_bank
);

    evt_t hw_evt, seq_evt, sw_evt;

    assign sw_evt = make_evt(sw_code, sw_we);

    evg_trig_in #(.NUM_TRIG(NUM_TRIG)) u_trig (
        .clk      (clk),
        .rst      (rst),
        .trig_in  (trig_in),
        .cfg_we   (trig_cfg_we),
        .cfg_idx  (trig_cfg_idx),
        .cfg_code (trig_cfg_code),
        .hw_evt   (hw_evt)
    );

    evg_seq #(.DEPTH(DEPTH), .STEP_W(STEP_W), .DIV_W(DIV_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ram_we),
        .wr_bank  (ram_bank),
        .wr_addr  (ram_addr),
        .wr_code  (ram_code),
        .wr_step  (ram_step),
        .bank_req (bank_req),
        .step_div (step_div),
        .rev_tick (rev_tick),
        .ref_trig (ref_trig),
        .seq_evt  (seq_evt),
        .busy     (seq_busy),
        .active   (active_bank)
    );

    evg_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .hw_evt    (hw_evt),
        .seq_evt   (seq_evt),
        .sw_evt    (sw_evt),
        .dclk_bits (dclk_bits),
        .frame_out (frame_out)
    );

endmodule

// File: tb/test_timing_event_gen.sv
module test_timing_event_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  trig_in = '0;
    logic        trig_cfg_we = 1'b0;
    logic [2:0]  trig_cfg_idx = '0;
    logic [7:0]  trig_cfg_code = '0;
    logic        sw_we = 1'b0;
    logic [7:0]  sw_code = '0;
    logic        ram_we = 1'b0;
    logic        ram_bank = 1'b0;
    logic [3:0]  ram_addr = '0;
    logic [7:0]  ram_code = '0;
    logic [11:0] ram_step = '0;
    logic        bank_req = 1'b0;
    logic [7:0]  step_div = 8'd2;
    logic        rev_tick = 1'b0;
    logic        ref_trig = 1'b0;
    logic [7:0]  dclk_bits = 8'hA5;
    logic [15:0] frame_out;
    logic        seq_busy;
    logic        active_bank;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    timing_event_gen i_timing_event_gen (
        .clk(clk), .rst(rst), .trig_in(trig_in),
        .trig_cfg_we(trig_cfg_we), .trig_cfg_idx(trig_cfg_idx), .trig_cfg_code(trig_cfg_code),
        .sw_we(sw_we), .sw_code(sw_code),
        .ram_we(ram_we), .ram_bank(ram_bank), .ram_addr(ram_addr),
        .ram_code(ram_code), .ram_step(ram_step),
        .bank_req(bank_req), .step_div(step_div), .rev_tick(rev_tick), .ref_trig(ref_trig),
        .dclk_bits(dclk_bits), .frame_out(frame_out),
        .seq_busy(seq_busy), .active_bank(active_bank)
    );

    task automatic nclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_code(int idx, logic [7:0] c);
        trig_cfg_we = 1'b1; trig_cfg_idx = 3'(idx); trig_cfg_code = c;
        nclk(1);
        trig_cfg_we = 1'b0;
    endtask

    task automatic put_entry(logic b, int a, logic [7:0] c, int st);
        ram_we = 1'b1; ram_bank = b; ram_addr = 4'(a); ram_code = c; ram_step = 12'(st);
        nclk(1);
        ram_we = 1'b0;
    endtask

    task automatic pulse_rev();
        rev_tick = 1'b1; nclk(1); rev_tick = 1'b0;
    endtask

    task automatic pulse_ref();
        ref_trig = 1'b1; nclk(1); ref_trig = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 frame", frame_out, 16'h0000);
        chk("R1 busy", {15'b0, seq_busy}, 16'h0);
        chk("R1 bank", {15'b0, active_bank}, 16'h0);
    endtask

    task automatic t_idle();
        rst = 1'b0;
        nclk(2);
        chk("R2 idle frame", frame_out, 16'hA500);
    endtask

    task automatic t_soft();
        sw_we = 1'b1; sw_code = 8'h21;
        nclk(1); sw_we = 1'b0;
        chk("R3 sw event", frame_out, 16'hA521);
        nclk(1);
        chk("R2 back to null", frame_out, 16'hA500);
        sw_we = 1'b1; sw_code = 8'h00;
        nclk(1); sw_we = 1'b0;
        chk("R3 null sw code", frame_out, 16'hA500);
    endtask

    task automatic t_hw();
        set_code(3, 8'h33);
        set_code(5, 8'h55);
        trig_in[3] = 1'b1;
        nclk(3);
        chk("R4 hw line 3", frame_out, 16'hA533);
        nclk(1);
        chk("R11 single frame", frame_out, 16'hA500);
        trig_in = '0; nclk(4);
        trig_in[3] = 1'b1; trig_in[5] = 1'b1;
        nclk(3);
        chk("R4 lowest line wins", frame_out, 16'hA533);
        nclk(1);
        chk("R4 other line dropped", frame_out, 16'hA500);
        trig_in = '0; nclk(4);
        trig_in[1] = 1'b1;
        nclk(3);
        chk("R4 unprogrammed line", frame_out, 16'hA500);
        trig_in = '0; nclk(4);
    endtask

    task automatic t_hw_vs_sw();
        trig_in[5] = 1'b1;
        nclk(2);
        sw_we = 1'b1; sw_code = 8'h44;
        nclk(1); sw_we = 1'b0;
        chk("R5 hw beats sw", frame_out, 16'hA555);
        nclk(1);
        chk("R5 sw held one cycle", frame_out, 16'hA544);
        trig_in = '0; nclk(4);
    endtask

    task automatic t_load();
        put_entry(1'b0, 0, 8'h10, 0);
        put_entry(1'b0, 1, 8'h11, 1);
        put_entry(1'b0, 2, 8'hFF, 0);
        put_entry(1'b1, 0, 8'h20, 0);
        put_entry(1'b1, 1, 8'hFF, 0);
        nclk(1);
    endtask

    task automatic t_play_bank0();
        pulse_ref();
        nclk(2);
        chk("R6 first entry", frame_out, 16'hA510);
        chk("R6 busy", {15'b0, seq_busy}, 16'h1);
        pulse_rev();
        nclk(2);
        chk("R7 no step before divide", frame_out, 16'hA500);
        pulse_ref();
        nclk(2);
        chk("R6 ref ignored while busy", frame_out, 16'hA500);
        put_entry(1'b0, 0, 8'h99, 0);
        bank_req = 1'b1;
        nclk(2);
        chk("R9 swap deferred", {15'b0, active_bank}, 16'h0);
        pulse_rev();
        nclk(2);
        chk("R7 entry at step 1", frame_out, 16'hA511);
        chk("R8 stop code ends run", {15'b0, seq_busy}, 16'h0);
        chk("R9 swap at end", {15'b0, active_bank}, 16'h1);
    endtask

    task automatic t_play_bank1();
        pulse_ref();
        nclk(1);
        sw_we = 1'b1; sw_code = 8'h45;
        nclk(1); sw_we = 1'b0;
        chk("R5 seq beats sw", frame_out, 16'hA520);
        nclk(1);
        chk("R5 sw after seq", frame_out, 16'hA545);
        chk("R8 bank1 ended", {15'b0, seq_busy}, 16'h0);
    endtask

    task automatic t_back_to_bank0();
        bank_req = 1'b0;
        nclk(2);
        chk("R9 idle follow", {15'b0, active_bank}, 16'h0);
        pulse_ref();
        nclk(2);
        chk("R10 busy write ignored", frame_out, 16'hA510);
        pulse_rev(); pulse_rev();
        nclk(4);
        chk("R8 run finished", {15'b0, seq_busy}, 16'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        nclk(3);
        t_reset();
        t_idle();
        t_soft();
        t_hw();
        t_hw_vs_sw();
        t_load();
        t_play_bank0();
        t_play_bank1();
        t_back_to_bank0();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule